// File: doc/BRIEF.md
# Sector-Addressed Flash Disk Address Generator

This block lets a host processor use a byte-wide flash memory as a small disk made of fixed-size sectors. It sits on the host's narrow parallel bus and decodes three port addresses. The host writes a sector number into a load register, one byte at a time with the low byte first. Each write of the low sector byte also returns a byte-offset counter to zero. After that the host only reads or writes the data port. Each data access steps the offset counter on its own, so no per-byte address writes are needed.

The flash address is the sector number in the upper bits joined to the byte offset in the lower bits. A parameter selects one of two geometries. The first gives 256 sectors of 512 bytes (8-bit sector, 9-bit offset, 17-bit address, 128K x 8 flash). The second gives 2048 sectors of 256 bytes (11-bit sector, 8-bit offset, 19-bit address, 512K x 8 flash). The block also drives the flash chip-enable, output-enable and write-enable strobes from the host's data-port strobes.

Top module: `flashdisk_addrgen`

## Requirements
- R1: A synchronous active-high reset clears the sector register and the offset counter, so `flash_addr` reads 0. With the host idle, all three flash strobes are low.
- R2: A host write to port 0 (sector-low) loads `host_wdata` into sector bits [7:0].
- R3: A host write to port 1 (sector-high) loads `host_wdata[2:0]` into sector bits [10:8] in the 2048-sector geometry. It has no effect in the 256-sector geometry. In both geometries it leaves the offset counter unchanged.
- R4: A host write to port 0 clears the offset counter to zero. If a clear and a step fall in the same cycle, the clear wins.
- R5: Each data-port access is a read or write strobe on port 2. At its trailing edge the offset counter advances by one, and the new value appears one clock after the strobe goes low. `flash_addr` holds steady while the strobe is high.
- R6: The offset counter wraps from its all-ones value to zero. It never carries into the sector register.
- R7: `flash_addr` equals the sector register in the upper bits concatenated with the offset counter in the lower bits. There are 9 offset bits in the 256-sector geometry and 8 in the 2048-sector geometry.
- R8: During a port-2 read, `flash_ce` and `flash_oe` follow `host_rd` and `flash_we` stays low. During a port-2 write, `flash_ce` and `flash_we` follow `host_wr` and `flash_oe` stays low.
- R9: Accesses to port 3, and reads of ports 0 and 1, leave the sector register and offset counter unchanged. Accesses to any port other than 2 assert no flash strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Host port select: 0 sector-low, 1 sector-high, 2 data, 3 unused |
| host_wdata | input | HOST_W | Host write data |
| host_rd | input | 1 | Host read strobe, active high |
| host_wr | input | 1 | Host write strobe, active high |
| flash_addr | output | SECT_W+BYTE_W | Flash address {sector, offset} |
| flash_ce | output | 1 | Flash chip enable, active high |
| flash_oe | output | 1 | Flash output enable, active high |
| flash_we | output | 1 | Flash write enable, active high |

## Verification
The bench writes all 2048 sector numbers into both geometries. A mistake in how the high sector byte is merged, or a small-geometry design that wrongly takes the high byte, would show up as a wrong upper address. It streams 512 data accesses, mixing reads and writes, through one sector. This catches a counter that stops at the sector end or carries into the sector bits on its 256th or 512th step. It also checks that the address stays fixed while a strobe is high, which a design that stepped on the leading edge would violate. Further accesses to ports 1 and 3, and reads of the sector ports, confirm that neither the offset nor the flash strobes react where they must not.

// File: rtl/flashdisk_pkg.sv
package flashdisk_pkg;

    typedef enum logic {
        GEOM_256X512  = 1'b0,
        GEOM_2048X256 = 1'b1
    } geom_e;

    typedef enum logic [1:0] {
        PORT_SECT_LO = 2'd0,
        PORT_SECT_HI = 2'd1,
        PORT_DATA    = 2'd2,
        PORT_SPARE   = 2'd3
    } port_e;

    typedef struct packed {
        logic ld_lo;
        logic ld_hi;
        logic step;
        logic dat_rd;
        logic dat_wr;
    } ctl_t;

    function automatic int byte_bits(geom_e g);
        return (g == GEOM_256X512) ? 9 : 8;
    endfunction

    function automatic int sect_bits(geom_e g);
        return (g == GEOM_256X512) ? 8 : 11;
    endfunction

endpackage

// File: rtl/fd_port_decode.sv
module fd_port_decode
    import flashdisk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] host_addr,
    input  logic       host_rd,
    input  logic       host_wr,
    output ctl_t       ctl
);
    logic sel_data;
    logic acc_now;
    logic acc_q;

    assign sel_data = (host_addr == PORT_DATA);
    assign acc_now  = sel_data && (host_rd || host_wr);

    always_ff @(posedge clk) begin
        if (rst) acc_q <= 1'b0;
        else     acc_q <= acc_now;
    end

    always_comb begin
        ctl.ld_lo  = host_wr && (host_addr == PORT_SECT_LO);
        ctl.ld_hi  = host_wr && (host_addr == PORT_SECT_HI);
        ctl.dat_rd = sel_data && host_rd;
        ctl.dat_wr = sel_data && host_wr;
        ctl.step   = acc_q && !acc_now;
    end

    // R5
    step_after_access_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.step |-> $past(ctl.dat_rd || ctl.dat_wr));

endmodule

// File: rtl/fd_sector_reg.sv
module fd_sector_reg #(
    parameter int SECT_W = 11,
    parameter int HOST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [HOST_W-1:0] wdata,
    output logic [SECT_W-1:0] sect
);
    localparam int LO_W = (SECT_W < HOST_W) ? SECT_W : HOST_W;
    localparam int HI_W = SECT_W - LO_W;

    logic [LO_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst)        lo_q <= '0;
        else if (ld_lo) lo_q <= wdata[LO_W-1:0];
    end

    generate
        if (HI_W > 0) begin : g_hi
            logic [HI_W-1:0] hi_q;
            always_ff @(posedge clk) begin
                if (rst)        hi_q <= '0;
                else if (ld_hi) hi_q <= wdata[HI_W-1:0];
            end
            assign sect = {hi_q, lo_q};

            // R3
            hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !ld_hi |=> $stable(sect[SECT_W-1:LO_W]));
        end else begin : g_nohi
            assign sect = lo_q;

            // R3
            hi_ignored_chk: assert property (@(posedge clk) disable iff (rst)
                (ld_hi && !ld_lo) |=> $stable(sect));
        end
    endgenerate

endmodule

// File: rtl/fd_offset_ctr.sv
module fd_offset_ctr #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    output logic [BYTE_W-1:0] off
);
    always_ff @(posedge clk) begin
        if (rst || clr) off <= '0;
        else if (step)  off <= off + 1'b1;
    end

    // R6
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && (off == {BYTE_W{1'b1}})) |=> (off == '0));

    // R4
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (off == '0));

endmodule

// File: rtl/flashdisk_addrgen.sv
module flashdisk_addrgen
    import flashdisk_pkg::*;
#(
    parameter geom_e GEOM   = GEOM_2048X256,
    parameter int    HOST_W = 8,
    parameter int    BYTE_W = byte_bits(GEOM),
    parameter int    SECT_W = sect_bits(GEOM),
    parameter int    ADDR_W = SECT_W + BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic              host_rd,
    input  logic              host_wr,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              flash_ce,
    output logic              flash_oe,
    output logic              flash_we
);
    ctl_t              ctl;
    logic [SECT_W-1:0] sect;
    logic [BYTE_W-1:0] off;
    logic              rst_q;

    fd_port_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .host_addr (host_addr),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .ctl       (ctl)
    );

    fd_sector_reg #(.SECT_W(SECT_W), .HOST_W(HOST_W)) u_sector (
        .clk   (clk),
        .rst   (rst),
        .ld_lo (ctl.ld_lo),
        .ld_hi (ctl.ld_hi),
        .wdata (host_wdata),
        .sect  (sect)
    );

    fd_offset_ctr #(.BYTE_W(BYTE_W)) u_offset (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctl.ld_lo),
        .step (ctl.step),
        .off  (off)
    );

    assign flash_addr = {sect, off};
    assign flash_oe   = ctl.dat_rd;
    assign flash_we   = ctl.dat_wr;
    assign flash_ce   = ctl.dat_rd || ctl.dat_wr;

    always_ff @(posedge clk) rst_q <= rst;

    // R1
    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            reset_clear_chk: assert (flash_addr == '0);
        end
    end

    // R5
    addr_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (flash_ce && $past(flash_ce)) |-> $stable(flash_addr));

    // R4
    lo_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == PORT_SECT_LO) |=> (flash_addr[BYTE_W-1:0] == '0));

    // R6
    no_carry_chk: assert property (@(posedge clk) disable iff (rst)
        !(host_wr && (host_addr == PORT_SECT_LO || host_addr == PORT_SECT_HI))
        |=> $stable(flash_addr[ADDR_W-1:BYTE_W]));

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flash_oe, flash_we}));

    // R9
    no_strobe_off_port_chk: assert property (@(posedge clk) disable iff (rst)
        (host_addr != PORT_DATA) |-> !flash_ce);

endmodule

// File: tb/test_flashdisk_addrgen.sv
`timescale 1ns/1ps
module test_flashdisk_addrgen;
    import flashdisk_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  host_addr = 2'd3;
    logic [7:0]  host_wdata = 8'd0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;

    logic [18:0] fa_l;
    logic        ce_l, oe_l, we_l;
    logic [16:0] fa_s;
    logic        ce_s, oe_s, we_s;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int sect_l = 0, off_l = 0, sect_s = 0, off_s = 0;

    always #2.5 clk = ~clk;

    flashdisk_addrgen #(.GEOM(GEOM_2048X256)) i_flashdisk_addrgen (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_wr(host_wr),
        .flash_addr(fa_l), .flash_ce(ce_l), .flash_oe(oe_l), .flash_we(we_l));

    flashdisk_addrgen #(.GEOM(GEOM_256X512)) i_flashdisk_addrgen_s (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_wr(host_wr),
        .flash_addr(fa_s), .flash_ce(ce_s), .flash_oe(oe_s), .flash_we(we_s));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_addr(input string tag);
        int el, es;
        el = (sect_l << 8) | off_l;
        es = (sect_s << 9) | off_s;
        chk(int'(fa_l) == el, {tag, " large"}, int'(fa_l), el);
        chk(int'(fa_s) == es, {tag, " small"}, int'(fa_s), es);
    endtask

    task automatic chk_strobes(input string tag, input int ce, input int oe, input int we);
        chk({ce_l, oe_l, we_l} == 3'(ce*4 + oe*2 + we), {tag, " large strobes"},
            int'({ce_l, oe_l, we_l}), ce*4 + oe*2 + we);
        chk({ce_s, oe_s, we_s} == 3'(ce*4 + oe*2 + we), {tag, " small strobes"},
            int'({ce_s, oe_s, we_s}), ce*4 + oe*2 + we);
    endtask

    task automatic wr_port(input int p, input int d);
        @(negedge clk);
        host_addr = 2'(p); host_wdata = 8'(d); host_wr = 1'b1;
        #1 chk_strobes("R9 reg write", 0, 0, 0);
        @(negedge clk);
        host_wr = 1'b0;
        if (p == 0) begin
            sect_l = (sect_l & 32'h700) | (d & 8'hff); off_l = 0;
            sect_s = d & 8'hff; off_s = 0;
        end else if (p == 1) begin
            sect_l = (sect_l & 32'hff) | ((d & 7) << 8);
        end
    endtask

    task automatic data_acc(input bit is_rd, input string tag);
        @(negedge clk);
        host_addr = 2'd2;
        if (is_rd) host_rd = 1'b1; else host_wr = 1'b1;
        #1;
        chk_strobes({"R8 ", tag}, 1, is_rd ? 1 : 0, is_rd ? 0 : 1);
        chk_addr({"R5 hold ", tag});
        @(negedge clk);
        chk_addr({"R5 hold2 ", tag});
        host_rd = 1'b0; host_wr = 1'b0;
        @(negedge clk);
        off_l = (off_l + 1) % 256;
        off_s = (off_s + 1) % 512;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        chk_addr("R1 reset");
        chk_strobes("R1 idle", 0, 0, 0);

        // R2 R3 R7: sweep every sector number
        for (int s = 0; s < 2048; s++) begin
            wr_port(0, s & 255);
            wr_port(1, s >> 8);
            #1 chk_addr("R2 R3 R7 sector sweep");
        end

        // R4: step offset, then clear by sector-low write
        wr_port(0, 8'h5a); wr_port(1, 3'd5);
        data_acc(1'b1, "step a");
        data_acc(1'b0, "step b");
        data_acc(1'b1, "step c");
        #1 chk_addr("R5 after 3 steps");
        chk(int'(fa_l[7:0]) == 3, "R5 offset three", int'(fa_l[7:0]), 3);
        wr_port(1, 3'd2);
        #1 chk_addr("R3 hi keeps offset");
        chk(int'(fa_l[7:0]) == 3, "R3 offset kept", int'(fa_l[7:0]), 3);
        wr_port(0, 8'h11);
        #1 chk_addr("R4 clear");
        chk(int'(fa_s[8:0]) == 0, "R4 small offset zero", int'(fa_s[8:0]), 0);

        // R5 R6: stream 512 accesses, both counters wrap
        for (int i = 0; i < 512; i++) begin
            data_acc(i[0], "stream");
            #1 chk_addr("R5 R6 stream");
        end
        chk(int'(fa_l[7:0]) == 0 && int'(fa_l[18:8]) == sect_l, "R6 large wrap",
            int'(fa_l), sect_l << 8);
        chk(int'(fa_s[8:0]) == 0 && int'(fa_s[16:9]) == sect_s, "R6 small wrap",
            int'(fa_s), sect_s << 9);

        // R9: ignored accesses
        data_acc(1'b0, "pre");
        @(negedge clk);
        host_addr = 2'd3; host_wr = 1'b1; host_wdata = 8'hff;
        #1 chk_strobes("R9 port3 write", 0, 0, 0);
        @(negedge clk); host_wr = 1'b0; host_rd = 1'b1;
        #1 chk_strobes("R9 port3 read", 0, 0, 0);
        @(negedge clk); host_addr = 2'd0;
        #1 chk_strobes("R9 port0 read", 0, 0, 0);
        @(negedge clk); host_addr = 2'd1;
        @(negedge clk); host_rd = 1'b0;
        @(negedge clk); @(negedge clk);
        #1 chk_addr("R9 no change");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule